// File: doc/BRIEF.md
# Data Translation Permission Checker

This block sits between a data-side address request and the translation buffer. Every request carries a 64-bit translation-control word, a virtual address, an access size, a write flag and a set of address-space class flags. From these the block derives the lookup key for the translation buffer: context, partition and whether the access is real or virtual. The buffer returns its hit and page attributes combinationally in the same cycle. The block then gives either a physical address with an uncacheable flag, or exactly one fault.

The outcome is registered and shows up one cycle after the request strobe. A translation fault also captures the faulting page address and context in a tag-access register. Hypervisor accesses can bypass translation altogether. Misaligned and out-of-range addresses are rejected before the lookup result is used.

Top module: `dtx_perm_check`

## Requirements
- R1: The lookup key outputs are combinational and built from the control word as follows:
  - Field positions in the word: hypervisor = bit 0, reset mode = bit 1, privileged = bit 2, address mask = bit 3, data translation enable = bit 5, partition = bits 15:8, trap level = bits 18:16, primary context = bits 47:32, secondary context = bits 63:48.
  - `lk_part` is the partition field.
  - `lk_ctx` depends on the class flags. For an implicit access it is 0 when the trap level is nonzero and the primary context otherwise. For a non-implicit access it is the secondary context when `cls_second` is set and the primary context otherwise.
- R2: An implicit access in hypervisor mode bypasses translation. It gives `pa` = `va`[39:0] with `uncache` = 0, even when the address is misaligned.
- R3: Outside that bypass, an access with (`va` AND (`acc_size`−1)) nonzero faults as misaligned, which is `fault_code` bit 0. This check comes before every other check.
- R4: Out-of-range check:
  - The effective address is `va`, or `va`[31:0] zero-extended when the address-mask bit is set.
  - An effective address whose bits 63:47 are not all equal faults as out of range, which is `fault_code` bit 1.
- R5: `lk_real` is 1 when the data translation enable, hypervisor and reset-mode bits are all clear, or when `cls_real` is set.
- R6: A non-implicit hypervisor access without `cls_real` that passes R3 and R4 bypasses translation, with `pa` = effective address[39:0] and `uncache` = 0.
- R7: A lookup miss faults as a real miss (bit 2) when `lk_real` is 1, and as a translation miss (bit 3) otherwise.
- R8: On a hit, a privileged page accessed with both the privileged and hypervisor bits clear faults as a privilege violation (bit 4). This check ranks above R9 to R11.
- R9: A write to a page that is not writable faults as a protection fault (bit 5). This check ranks above R10 and R11.
- R10: A no-fault-only page accessed without `cls_nofault` faults (bit 6). This check ranks above R11.
- R11: A side-effect page accessed with `cls_nofault` faults (bit 7).
- R12: Physical address on a successful translation:
  - The page size code k selects a page of 2^(13+3k) bytes.
  - `pa` takes `lk_frame` bits at and above 13+3k, and effective-address bits below that point.
- R13: A translated result is uncacheable when the page's side-effect bit is set or `pa` bit 39 is set.
- R14: Timing and tag capture:
  - `pa_vld` or `fault_vld` pulses exactly in the cycle after `req_vld`, and never both at once.
  - `fault_code` is one-hot while `fault_vld` is high and zero otherwise.
  - Only faults R7 to R11 load `tag_acc` with {effective address[63:13], `lk_ctx`[12:0]}. R3 and R4 faults leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| ctl_word | input | 64 | Translation-control word |
| va | input | 64 | Virtual address |
| acc_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| is_write | input | 1 | Store access |
| cls_implicit | input | 1 | Implicit address-space class |
| cls_real | input | 1 | Real address-space class |
| cls_nofault | input | 1 | No-fault address-space class |
| cls_second | input | 1 | Secondary-context class |
| lk_ctx | output | 16 | Context used for the lookup |
| lk_part | output | 8 | Partition used for the lookup |
| lk_real | output | 1 | Lookup is a real translation |
| lk_hit | input | 1 | Lookup hit |
| lk_frame | input | 40 | Page frame address of the hit |
| lk_pgsz | input | 3 | Page size code of the hit |
| lk_priv | input | 1 | Page is privileged |
| lk_writable | input | 1 | Page is writable |
| lk_nofault | input | 1 | Page is no-fault only |
| lk_sideeff | input | 1 | Page has side effects |
| pa_vld | output | 1 | Physical address valid |
| pa | output | 40 | Physical address |
| uncache | output | 1 | Result is uncacheable |
| fault_vld | output | 1 | Fault valid |
| fault_code | output | 8 | One-hot fault code |
| tag_acc | output | 64 | Faulting page and context |

## Verification
The bench aims at the priority chain. It builds pages that break several permission rules at once, so a design that checked the rules in a different order would report the lower-ranked fault. It also drives a misaligned hypervisor implicit access, which would fault wrongly if alignment were checked ahead of the bypass. A misaligned fault that follows a miss must leave `tag_acc` unchanged; a design that captured the tag on every fault would overwrite it. Several page sizes and a frame with bit 39 set expose wrong offset masks and a missing uncacheable rule. The address-mask case sends an address from the hole that must translate once it is truncated.

// File: rtl/dtx_perm_check.sv
module dtx_perm_check #(
  parameter int VA_BITS = 48,
  parameter int PA_BITS = 40,
  parameter int UC_BIT  = 39
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [63:0]        ctl_word,
  input  logic [63:0]        va,
  input  logic [3:0]         acc_size,
  input  logic               is_write,
  input  logic               cls_implicit,
  input  logic               cls_real,
  input  logic               cls_nofault,
  input  logic               cls_second,
  output logic [15:0]        lk_ctx,
  output logic [7:0]         lk_part,
  output logic               lk_real,
  input  logic               lk_hit,
  input  logic [PA_BITS-1:0] lk_frame,
  input  logic [2:0]         lk_pgsz,
  input  logic               lk_priv,
  input  logic               lk_writable,
  input  logic               lk_nofault,
  input  logic               lk_sideeff,
  output logic               pa_vld,
  output logic [PA_BITS-1:0] pa,
  output logic               uncache,
  output logic               fault_vld,
  output logic [7:0]         fault_code,
  output logic [63:0]        tag_acc
);
  localparam int PG_BASE = 13;
  localparam int F_ALIGN = 0, F_RANGE = 1, F_RMISS = 2, F_MISS = 3;
  localparam int F_PRIV = 4, F_PROT = 5, F_NFO = 6, F_SE = 7;

  logic        hp, rmode, prv, amask, dmmu;
  logic [2:0]  tl;
  logic [15:0] pri_ctx, sec_ctx;
  logic        unused_ctl;

  assign hp      = ctl_word[0];
  assign rmode   = ctl_word[1];
  assign prv     = ctl_word[2];
  assign amask   = ctl_word[3];
  assign dmmu    = ctl_word[5];
  assign lk_part = ctl_word[15:8];
  assign tl      = ctl_word[18:16];
  assign pri_ctx = ctl_word[47:32];
  assign sec_ctx = ctl_word[63:48];
  assign unused_ctl = ^{ctl_word[31:19], ctl_word[7:6], ctl_word[4]};

  assign lk_ctx  = cls_implicit ? ((tl != 3'd0) ? 16'd0 : pri_ctx)
                                : (cls_second ? sec_ctx : pri_ctx);
  assign lk_real = (!dmmu && !hp && !rmode) || cls_real;

  logic [63:0]        va_eff;
  logic               misal, out_rng, byp_imp, byp_hyp;
  logic [5:0]         pg_shift;
  logic [PA_BITS-1:0] off_mask, xl_pa;

  assign va_eff   = amask ? {32'd0, va[31:0]} : va;
  assign misal    = |(va[3:0] & (acc_size - 4'd1));
  assign out_rng  = !((&va_eff[63:VA_BITS-1]) || !(|va_eff[63:VA_BITS-1]));
  assign byp_imp  = hp && cls_implicit;
  assign byp_hyp  = hp && !cls_real;
  assign pg_shift = 6'(PG_BASE) + 6'(lk_pgsz) * 6'd3;
  assign off_mask = ~({PA_BITS{1'b1}} << pg_shift);
  assign xl_pa    = (lk_frame & ~off_mask) | (va_eff[PA_BITS-1:0] & off_mask);

  logic [7:0]         fc;
  logic               take;
  logic [PA_BITS-1:0] pa_n;
  logic               uc_n;

  always_comb begin
    fc   = '0;
    take = 1'b0;
    pa_n = '0;
    uc_n = 1'b0;
    if (byp_imp) begin
      take = 1'b1;
      pa_n = va[PA_BITS-1:0];
    end else if (misal)                      fc[F_ALIGN] = 1'b1;
    else if (out_rng)                        fc[F_RANGE] = 1'b1;
    else if (byp_hyp) begin
      take = 1'b1;
      pa_n = va_eff[PA_BITS-1:0];
    end else if (!lk_hit) begin
      if (lk_real) fc[F_RMISS] = 1'b1;
      else         fc[F_MISS]  = 1'b1;
    end
    else if (!prv && !hp && lk_priv)         fc[F_PRIV] = 1'b1;
    else if (is_write && !lk_writable)       fc[F_PROT] = 1'b1;
    else if (lk_nofault && !cls_nofault)     fc[F_NFO]  = 1'b1;
    else if (lk_sideeff && cls_nofault)      fc[F_SE]   = 1'b1;
    else begin
      take = 1'b1;
      pa_n = xl_pa;
      uc_n = lk_sideeff || xl_pa[UC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_vld     <= 1'b0;
      fault_vld  <= 1'b0;
      fault_code <= '0;
      pa         <= '0;
      uncache    <= 1'b0;
      tag_acc    <= '0;
    end else begin
      pa_vld     <= req_vld && take;
      fault_vld  <= req_vld && !take;
      fault_code <= req_vld ? fc : 8'd0;
      if (req_vld && take) begin
        pa      <= pa_n;
        uncache <= uc_n;
      end
      if (req_vld && (|fc[7:2]))
        tag_acc <= {va_eff[63:PG_BASE], lk_ctx[PG_BASE-1:0]};
    end
  end
endmodule

module dtx_perm_check_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [63:0] va,
  input logic [3:0]  acc_size,
  input logic        pa_vld,
  input logic        fault_vld,
  input logic [7:0]  fault_code,
  input logic [63:0] tag_acc
);
  // R14
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_vld && fault_vld));
  // R14
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |-> $countones(fault_code) == 1);
  // R14
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_vld |-> fault_code == 8'd0);
  // R14
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (pa_vld || fault_vld));
  // R14
  resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_vld || fault_vld) |-> $past(req_vld));
  // R3
  align_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && fault_code[0]) |-> $past(|(va[3:0] & (acc_size - 4'd1))));
  // R14
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag_acc) |-> (fault_vld && !fault_code[0] && !fault_code[1]));
endmodule

bind dtx_perm_check dtx_perm_check_chk u_chk (.*);

// File: tb/dtx_perm_check_tb.sv
module dtx_perm_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [63:0] ctl_word, va;
  logic [3:0]  acc_size;
  logic        is_write, cls_implicit, cls_real, cls_nofault, cls_second;
  logic [15:0] lk_ctx;
  logic [7:0]  lk_part;
  logic        lk_real, lk_hit;
  logic [39:0] lk_frame;
  logic [2:0]  lk_pgsz;
  logic        lk_priv, lk_writable, lk_nofault, lk_sideeff;
  logic        pa_vld, uncache, fault_vld;
  logic [39:0] pa;
  logic [7:0]  fault_code;
  logic [63:0] tag_acc;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dtx_perm_check u_dut (.*);

  function automatic logic [63:0] mk_ctl(bit hp, bit rm, bit pr, bit am, bit dm,
                                         logic [7:0] part, logic [2:0] tl,
                                         logic [15:0] pri, logic [15:0] sec);
    return {sec, pri, 13'd0, tl, part, 2'b00, dm, 1'b0, am, pr, rm, hp};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    ctl_word = mk_ctl(0, 0, 0, 0, 1, 8'h3c, 3'd0, 16'h1234, 16'h5678);
    va = 64'h0000_1234_5678_9000; acc_size = 4'd8; is_write = 1'b0;
    cls_implicit = 1'b0; cls_real = 1'b0; cls_nofault = 1'b0; cls_second = 1'b0;
    lk_hit = 1'b1; lk_frame = 40'h12_3456_0000; lk_pgsz = 3'd0;
    lk_priv = 1'b0; lk_writable = 1'b1; lk_nofault = 1'b0; lk_sideeff = 1'b0;
  endtask

  task automatic fire();
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic expect_fault(string tag, logic [7:0] code);
    chk({tag, " fault_vld"}, 64'(fault_vld), 64'd1);
    chk({tag, " pa_vld"}, 64'(pa_vld), 64'd0);
    chk({tag, " code"}, 64'(fault_code), 64'(code));
  endtask

  task automatic expect_pa(string tag, logic [39:0] a, bit uc);
    chk({tag, " pa_vld"}, 64'(pa_vld), 64'd1);
    chk({tag, " fault_vld"}, 64'(fault_vld), 64'd0);
    chk({tag, " pa"}, 64'(pa), 64'(a));
    chk({tag, " uncache"}, 64'(uncache), 64'(uc));
  endtask

  task automatic t_reset();
    chk("R14 reset pa_vld", 64'(pa_vld), 64'd0);
    chk("R14 reset fault_vld", 64'(fault_vld), 64'd0);
    chk("R14 reset tag", tag_acc, 64'd0);
  endtask

  task automatic t_key();
    defaults(); #1;
    chk("R1 part", 64'(lk_part), 64'h3c);
    chk("R1 primary", 64'(lk_ctx), 64'h1234);
    chk("R5 virtual", 64'(lk_real), 64'd0);
    cls_second = 1'b1; #1;
    chk("R1 secondary", 64'(lk_ctx), 64'h5678);
    cls_second = 1'b0; cls_implicit = 1'b1;
    ctl_word = mk_ctl(0, 0, 0, 0, 1, 8'h3c, 3'd2, 16'h1234, 16'h5678); #1;
    chk("R1 nucleus", 64'(lk_ctx), 64'h0);
    ctl_word = mk_ctl(0, 0, 0, 0, 0, 8'h3c, 3'd0, 16'h1234, 16'h5678); #1;
    chk("R1 implicit primary", 64'(lk_ctx), 64'h1234);
    chk("R5 mmu off", 64'(lk_real), 64'd1);
    ctl_word = mk_ctl(0, 1, 0, 0, 0, 8'h3c, 3'd0, 16'h1234, 16'h5678); #1;
    chk("R5 reset mode", 64'(lk_real), 64'd0);
    ctl_word = mk_ctl(0, 0, 0, 0, 1, 8'h3c, 3'd0, 16'h1234, 16'h5678);
    cls_real = 1'b1; #1;
    chk("R5 real class", 64'(lk_real), 64'd1);
  endtask

  task automatic t_bypass();
    defaults();
    ctl_word = mk_ctl(1, 0, 0, 0, 1, 8'h3c, 3'd0, 16'h1234, 16'h5678);
    cls_implicit = 1'b1; va = 64'hFFFF_FFAB_CDEF_0123; acc_size = 4'd4;
    lk_hit = 1'b0;
    fire();
    expect_pa("R2 bypass", 40'hAB_CDEF_0123, 1'b0);
    defaults();
    ctl_word = mk_ctl(1, 0, 0, 0, 1, 8'h3c, 3'd0, 16'h1234, 16'h5678);
    va = 64'h0000_0000_1234_5678; lk_hit = 1'b0;
    fire();
    expect_pa("R6 hyper", 40'h00_1234_5678, 1'b0);
  endtask

  task automatic t_miss();
    defaults(); lk_hit = 1'b0;
    fire();
    expect_fault("R7 mmu miss", 8'h08);
    chk("R14 tag", tag_acc, 64'h0000_1234_5678_9234);
    defaults(); lk_hit = 1'b0; va = 64'h0000_0000_0000_a000;
    ctl_word = mk_ctl(0, 0, 0, 0, 0, 8'h3c, 3'd0, 16'h1234, 16'h5678);
    fire();
    expect_fault("R7 real miss", 8'h04);
    chk("R14 tag real", tag_acc, 64'h0000_0000_0000_b234);
  endtask

  task automatic t_align_range();
    defaults(); va = 64'h0000_0000_0000_2004; lk_hit = 1'b0;
    fire();
    expect_fault("R3 misalign", 8'h01);
    chk("R14 tag kept", tag_acc, 64'h0000_0000_0000_b234);
    defaults(); va = 64'h0000_8000_0000_0000;
    fire();
    expect_fault("R4 hole", 8'h02);
    ctl_word = mk_ctl(0, 0, 0, 1, 1, 8'h3c, 3'd0, 16'h1234, 16'h5678);
    fire();
    expect_pa("R4 masked", 40'h12_3456_0000, 1'b0);
    defaults(); va = 64'hFFFF_FFFF_FFFF_E000;
    fire();
    chk("R4 upper half", 64'(pa_vld), 64'd1);
  endtask

  task automatic t_order();
    defaults(); lk_priv = 1'b1; lk_writable = 1'b0; lk_nofault = 1'b1;
    lk_sideeff = 1'b1; is_write = 1'b1; cls_nofault = 1'b1;
    fire();
    expect_fault("R8 priv", 8'h10);
    ctl_word = mk_ctl(0, 0, 1, 0, 1, 8'h3c, 3'd0, 16'h1234, 16'h5678);
    fire();
    expect_fault("R9 protect", 8'h20);
    is_write = 1'b0; cls_nofault = 1'b0;
    fire();
    expect_fault("R10 nofault", 8'h40);
    cls_nofault = 1'b1;
    fire();
    expect_fault("R11 side effect", 8'h80);
    cls_nofault = 1'b0; lk_nofault = 1'b0;
    fire();
    expect_pa("R13 side effect uc", 40'h12_3456_1000, 1'b1);
    defaults(); is_write = 1'b1;
    fire();
    expect_pa("R9 writable", 40'h12_3456_1000, 1'b0);
  endtask

  task automatic t_pa();
    defaults(); lk_pgsz = 3'd1;
    fire();
    expect_pa("R12 64K", 40'h12_3456_9000, 1'b0);
    lk_pgsz = 3'd3;
    fire();
    expect_pa("R12 4M", 40'h12_3478_9000, 1'b0);
    lk_pgsz = 3'd0; lk_frame = 40'h92_3456_0000;
    fire();
    expect_pa("R13 bit39", 40'h92_3456_1000, 1'b1);
    @(negedge clk);
    chk("R14 pulse", 64'(pa_vld), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key();
    t_bypass();
    t_miss();
    t_align_range();
    t_order();
    t_pa();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule